// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Serializer

This block converts a parallel word into a serial bit stream. Its chain of storage stages can be loaded all at once from a set of parallel inputs, or shifted one place at a time. Each shift moves data from stage A, the stage next to the serial input, toward stage H, the last stage. The last stage is brought out in both true and inverted form. The whole block runs on one fast system clock. The external shift clock, its companion gating input, the active-low load control and the serial input are treated as slow signals. They are synchronized into the system clock domain before they are used.

The shift clock is qualified by two interchangeable inputs. The block takes their OR, and a shift occurs on each rising edge of that OR. Holding either input high therefore freezes the register, and the other input then acts as a clock inhibit. The load control acts on its level and always wins. While it is low, every stage follows its parallel input, whatever the clock, inhibit and serial inputs are doing.

Top module: `pls_serializer`

## Requirements
- R1: While `load_n` is low, every stage takes its parallel input (`par_in[0]` into stage A through `par_in[7]` into stage H), whatever `clk_a`, `clk_b` and `ser_in` do. A level applied before system edge k is in the stages after edge k+2.
- R2: Loading follows the level of `par_in`. If `par_in` changes while `load_n` stays low, the stages end up holding the last value applied.
- R3: While either `clk_a` or `clk_b` is held high, rising edges on the other input cause no shift.
- R4: With `load_n` high, each rising edge of (`clk_a` OR `clk_b`) shifts the register exactly once. Stage A takes `ser_in` and every other stage takes the old value of the stage below it. The shift is visible after the third system edge following the input change.
- R5: With `load_n` high and no rising edge of the gated clock, all stages keep their values, however `ser_in` and `par_in` change.
- R6: `q_last` equals stage H and `q_last_n` is always its complement.
- R7: If the second gating input is raised while the first is already high, and the two are then released in turn, the register makes exactly one shift.
- R8: Synchronous active-high reset clears every stage to 0. Clock inputs that are high when reset is released do not produce a shift.
- R9: After a load, the bits that appear on `q_last` are `par_in[7]` first, then `par_in[6]`, and so on down to `par_in[0]`, one per shift.
- R10: When a low `load_n` and a rising gated-clock edge reach the register in the same system cycle, the load is applied and the edge is dropped.

Latency: the load path, the serial input and the gating inputs each pass through the same synchronizer, so they all take effect with the same delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load control, active low, level driven |
| clk_a | input | 1 | Gating clock input, interchangeable with clk_b |
| clk_b | input | 1 | Gating clock input, interchangeable with clk_a |
| ser_in | input | 1 | Serial data into stage A |
| par_in | input | STAGES | Parallel data; bit 0 goes to stage A |
| q_last | output | 1 | Last stage (H), true |
| q_last_n | output | 1 | Last stage (H), complement |

## Verification
A parallel load and a gated-clock rising edge can reach the register in the same system cycle. The bench provokes this by lowering `load_n` and raising `clk_a` at the same input edge, so both pass through the synchronizer together. It then releases `load_n` while `clk_a` is still high. The outcome is judged by shifting the register out: the bits must match the loaded word exactly, which shows that no extra shift was applied on top of the load, neither during the overlap nor after the release.

// File: rtl/pls_pkg.sv
package pls_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } op_e;

    typedef struct packed {
        logic load_n;
        logic gate_a;
        logic gate_b;
        logic ser;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Reset image: no load, both gates high so no edge at reset release
    localparam ctl_t CTL_IDLE = '{load_n: 1'b1, gate_a: 1'b1, gate_b: 1'b1, ser: 1'b0};

    // Load outranks shift, shift outranks hold
    function automatic op_e pick_op(input logic load_n, input logic rise);
        if (!load_n) begin
            return OP_LOAD;
        end
        if (rise) begin
            return OP_SHIFT;
        end
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/pls_sync.sv
module pls_sync #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_flop
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[DEPTH-1];

endmodule

// File: rtl/pls_edge.sv
module pls_edge (
    input  logic clk,
    input  logic rst,
    input  logic gate,
    output logic rise
);

    logic hist;

    // History starts high so a gate already high at reset release is no edge
    always_ff @(posedge clk) begin
        if (rst) hist <= 1'b1;
        else     hist <= gate;
    end

    assign rise = gate & ~hist;

    // R4: one gate rising yields a single shift request
    p_one_shot_r4: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

    // R8: no shift request in the first cycle after reset
    p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rise);

endmodule

// File: rtl/pls_stages.sv
module pls_stages
    import pls_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [STAGES-1:0] par,
    input  logic              ser,
    output logic [STAGES-1:0] st
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic from_below;
        if (g == 0) begin : g_head
            assign from_below = ser;
        end else begin : g_body
            assign from_below = st[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st[g] <= 1'b0;
            end else begin
                unique case (op)
                    OP_LOAD:  st[g] <= par[g];
                    OP_SHIFT: st[g] <= from_below;
                    default:  st[g] <= st[g];
                endcase
            end
        end
    end

    // R1: a load request copies the parallel word
    p_load_copies_r1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> (st == $past(par)));

    // R4: a shift request moves every stage up by one place
    p_shift_moves_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (st[0] == $past(ser)) && (st[LAST:1] == $past(st[LAST-1:0])));

    // R5: with no request the stages keep their contents
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(st));

endmodule

// File: rtl/pls_serializer.sv
module pls_serializer
    import pls_pkg::*;
#(
    parameter int STAGES     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    output logic              q_last,
    output logic              q_last_n
);

    localparam int LAST = STAGES - 1;

    ctl_t             ctl_raw;
    ctl_t             ctl_s;
    logic [CTL_W-1:0] ctl_s_bits;
    logic             gate;
    logic             rise;
    op_e              op;
    logic [STAGES-1:0] stages;

    assign ctl_raw = '{load_n: load_n, gate_a: clk_a, gate_b: clk_b, ser: ser_in};

    pls_sync #(
        .WIDTH   (CTL_W),
        .DEPTH   (SYNC_DEPTH),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s_bits)
    );

    assign ctl_s = ctl_t'(ctl_s_bits);
    assign gate  = ctl_s.gate_a | ctl_s.gate_b;

    pls_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .gate (gate),
        .rise (rise)
    );

    assign op = pick_op(ctl_s.load_n, rise);

    pls_stages #(
        .STAGES (STAGES)
    ) u_stages (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .par (par_in),
        .ser (ctl_s.ser),
        .st  (stages)
    );

    assign q_last   = stages[LAST];
    assign q_last_n = ~stages[LAST];

    // R3: input A held high blocks edges coming from input B
    p_inhibit_a_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_s.gate_a && $past(ctl_s.gate_a)) |-> !rise);

    // R3: input B held high blocks edges coming from input A
    p_inhibit_b_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_s.gate_b && $past(ctl_s.gate_b)) |-> !rise);

    // R10: a synchronized low load always selects loading
    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        !ctl_s.load_n |-> (op == OP_LOAD));

endmodule

// File: tb/tb_pls_serializer.sv
module tb_pls_serializer;

    localparam int N = 8;

    typedef struct {
        string tag;
        logic  exp;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b1;
    logic         clk_a = 1'b1;
    logic         clk_b = 1'b1;
    logic         ser_in = 1'b1;
    logic [N-1:0] par_in = '0;
    logic         q_last;
    logic         q_last_n;

    item_t        sb[$];
    logic [N-1:0] mdl;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    pls_serializer #(.STAGES(N), .SYNC_DEPTH(2)) dut (
        .clk      (clk),
        .rst      (rst),
        .load_n   (load_n),
        .clk_a    (clk_a),
        .clk_b    (clk_b),
        .ser_in   (ser_in),
        .par_in   (par_in),
        .q_last   (q_last),
        .q_last_n (q_last_n)
    );

    // Monitor: pops expected items and compares both outputs
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (q_last !== it.exp || q_last_n !== ~it.exp) begin
                    n_bad++;
                    $display("FAIL %s: q_last=%b q_last_n=%b expected %b/%b",
                             it.tag, q_last, q_last_n, it.exp, ~it.exp);
                end
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_q(input string tag);
        @(posedge clk);
        #2;
        sb.push_back('{tag: tag, exp: mdl[N-1]});
    endtask

    task automatic shift_on(input bit use_b, input logic s);
        @(negedge clk);
        ser_in = s;
        if (use_b) clk_b = 1'b1; else clk_a = 1'b1;
        wait_n(3);
        mdl = {mdl[N-2:0], s};
        if (use_b) clk_b = 1'b0; else clk_a = 1'b0;
        wait_n(3);
    endtask

    task automatic load_word(input logic [N-1:0] p);
        @(negedge clk);
        par_in = p;
        load_n = 1'b0;
        wait_n(3);
        mdl = p;
        load_n = 1'b1;
        wait_n(3);
    endtask

    // Reads out every stage through q_last, alternating the two clock inputs
    task automatic drain(input string tag);
        for (int i = 0; i < N; i++) begin
            expect_q(tag);
            shift_on(i[0], 1'b0);
        end
    endtask

    task automatic finish_run();
        wait_n(4);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        mdl = '0;
        // R8: reset with both clock inputs high and serial high
        wait_n(4);
        rst = 1'b0;
        wait_n(6);
        expect_q("R8 reset state");
        @(negedge clk);
        clk_a = 1'b0;
        clk_b = 1'b0;
        wait_n(3);
        drain("R8 no shift at reset release");

        // R1 R9 R6 R4: load, then shift out with new serial data
        load_word(8'b1011_0010);
        expect_q("R6 complement after load");
        for (int i = 0; i < 12; i++) begin
            logic [11:0] pat;
            pat = 12'hA5C;
            shift_on(i[1], pat[i]);
            expect_q(i < 7 ? "R9 load order" : "R4 serial entry");
        end

        // R1: load is unaffected by clock and serial activity
        @(negedge clk);
        par_in = 8'h5A;
        load_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            clk_a  = ~clk_a;
            ser_in = ~ser_in;
        end
        clk_a = 1'b0;
        wait_n(3);
        load_n = 1'b1;
        wait_n(3);
        mdl = 8'h5A;
        drain("R1 load ignores clocks");

        // R2: level-driven load tracks a changing word
        @(negedge clk);
        par_in = 8'h0F;
        load_n = 1'b0;
        wait_n(4);
        par_in = 8'hE1;
        wait_n(4);
        load_n = 1'b1;
        wait_n(3);
        mdl = 8'hE1;
        drain("R2 level load");

        // R3: raising B shifts once, then A pulses are blocked
        load_word(8'hC5);
        @(negedge clk);
        ser_in = 1'b1;
        clk_b = 1'b1;
        wait_n(3);
        mdl = {mdl[N-2:0], 1'b1};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            ser_in = i[0];
            clk_a = 1'b1;
            wait_n(3);
            clk_a = 1'b0;
            wait_n(3);
        end
        clk_b = 1'b0;
        wait_n(3);
        drain("R3 inhibit by B");

        // R3: mirror case, A held high while B pulses
        load_word(8'h69);
        @(negedge clk);
        ser_in = 1'b0;
        clk_a = 1'b1;
        wait_n(3);
        mdl = {mdl[N-2:0], 1'b0};
        @(negedge clk);
        ser_in = 1'b1;
        clk_b = 1'b1;
        wait_n(3);
        clk_b = 1'b0;
        wait_n(3);
        clk_a = 1'b0;
        wait_n(3);
        drain("R3 inhibit by A");

        // R7: inhibit raised while clock is high gives a single shift
        load_word(8'h3C);
        @(negedge clk);
        ser_in = 1'b1;
        clk_a = 1'b1;
        wait_n(3);
        mdl = {mdl[N-2:0], 1'b1};
        clk_b = 1'b1;
        wait_n(3);
        clk_a = 1'b0;
        wait_n(3);
        clk_b = 1'b0;
        wait_n(3);
        drain("R7 inhibit while high");

        // R10: load and clock edge arrive in the same cycle
        @(negedge clk);
        par_in = 8'h96;
        load_n = 1'b0;
        clk_a  = 1'b1;
        ser_in = 1'b1;
        wait_n(3);
        load_n = 1'b1;
        wait_n(3);
        clk_a = 1'b0;
        wait_n(3);
        mdl = 8'h96;
        drain("R10 load beats edge");

        // R5: idle with serial and parallel activity, no edges
        load_word(8'hA7);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ser_in = ~ser_in;
            par_in = par_in + 8'd37;
        end
        wait_n(3);
        drain("R5 hold");

        done = 1'b1;
        finish_run();
    end

endmodule